// File: doc/BRIEF.md
# Dithered DAC Code Sequencer

This block widens an 8-bit DAC to 9, 10, 11 or 12 bits. It does so by alternating the DAC between two neighbouring 8-bit codes in a fixed repeating pattern, and an external low-pass filter averages that pattern. A wide target code is split into an 8-bit base code and a fraction `k`. Over each pattern period of `P = 2^(B-8)` samples, where `B` is the selected resolution, `k` of the samples carry `base+1` and the rest carry `base`. The averaged output then lands `k/P` of an 8-bit step above `base`.

Each pulse of the sample enable writes one pattern slot to the DAC data output. One cycle after each new data value, the block issues a strobe so the DAC can latch it. A code loaded on the load strobe waits until the next pattern boundary before it takes effect. This keeps every period to a single target. Codes above the largest value that can be reproduced are held at that value.

Top module: `dither_seq`

## Requirements
- R1: `res_sel` selects the resolution: 0, 1, 2 and 3 give 9, 10, 11 and 12 bits, with a pattern period `P` of 2, 4, 8 and 16 samples.
- R2: The base code is the target code shifted right by `res_sel+1`, so it is the upper 8 bits of the B-bit code. The fraction `k` is the low `res_sel+1` bits.
- R3: Within a period the slots are numbered 1 to `P`. Slots `P-k+1` to `P` output `base+1`, and all earlier slots output `base`. When `k=0`, every slot outputs `base`.
- R4: A target above `255*P` (510, 1020, 2040 or 4080) gives the same output as `255*P`, which is 255 in every slot. `code_in` is read as a 12-bit unsigned value.
- R5: A code captured by `code_ld` is applied only from the first slot of the next period. If several loads arrive before that slot, the last one wins. A period that is already running keeps its target.
- R6: Each cycle with `sample_en` high writes one slot to `dac_data` and advances the slot, which wraps from slot `P` back to slot 1. Without `sample_en`, `dac_data` holds.
- R7: When `res_sel` changes, the pattern restarts at slot 1 under the new resolution, using the pending code.
- R8: `dac_strobe` is high in the cycle that follows each cycle in which `dac_data` took a sampled value. It is low at all other times.
- R9: After reset, `dac_data` is 0, `dac_strobe` is 0, the pending and active targets are 0, and the next sample is slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Sample-clock enable; each high cycle emits one slot |
| code_ld | input | 1 | Captures `code_in` as the pending target |
| code_in | input | DACW+EXTW | Target code |
| res_sel | input | 2 | Resolution select (B = 9 + res_sel) |
| dac_data | output | DACW | Code to the DAC |
| dac_strobe | output | 1 | DAC latch pulse, one cycle after each data update |

## Verification
The bench builds the block with its default parameters, an 8-bit DAC and up to four extra bits. This brings all four resolutions, and periods of 2 to 16 slots, within reach in one run. Random codes are loaded at arbitrary points inside a period, including codes past the clamp limit, and resolution changes land in mid-period. This exercises the boundary deferral, the restart and the flat top against a model of the slot order. Directed cases pin the exact slot positions of `base+1` at `k` = 1, 2 and `P-1`.

// File: rtl/dither_seq.sv
module dither_seq #(
  parameter int DACW = 8,
  parameter int EXTW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic                 code_ld,
  input  logic [DACW+EXTW-1:0] code_in,
  input  logic [1:0]           res_sel,
  output logic [DACW-1:0]      dac_data,
  output logic                 dac_strobe
);
  localparam int CODEW = DACW + EXTW;
  localparam int SLOTW = EXTW;
  localparam int PW    = EXTW + 1;

  logic [CODEW-1:0] pend, act, cur, clamped, lim, mask;
  logic [SLOTW-1:0] slot, slot_use, nxt_slot;
  logic [PW-1:0]    per, frac;
  logic [DACW-1:0]  base, nxt_data;
  logic [1:0]       res_q;
  logic             chg, hi, fire;
  int unsigned      sh;

  assign chg = res_sel != res_q;

  always_comb begin
    sh       = 32'(res_sel) + 32'd1;
    per      = PW'(1) << sh;
    lim      = CODEW'((1 << DACW) - 1) << sh;
    mask     = (CODEW'(1) << sh) - CODEW'(1);
    slot_use = chg ? '0 : slot;
    cur      = (slot_use == '0) ? pend : act;
    clamped  = (cur > lim) ? lim : cur;
    base     = DACW'(clamped >> sh);
    frac     = PW'(clamped & mask);
    hi       = PW'(slot_use) >= (per - frac);
    nxt_data = base + DACW'(hi);
    nxt_slot = (PW'(slot_use) == per - PW'(1)) ? '0 : slot_use + SLOTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= '0;
      act        <= '0;
      slot       <= '0;
      res_q      <= '0;
      dac_data   <= '0;
      fire       <= 1'b0;
      dac_strobe <= 1'b0;
    end else begin
      res_q      <= res_sel;
      fire       <= sample_en;
      dac_strobe <= fire;
      if (code_ld) pend <= code_in;
      if (sample_en) begin
        dac_data <= nxt_data;
        slot     <= nxt_slot;
        if (slot_use == '0) act <= pend;
      end else if (chg) begin
        slot <= '0;
      end
    end
  end

  assert_slot_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(slot) < (PW'(1) << (32'(res_q) + 32'd1)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(dac_data));

  assert_two_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && slot_use != '0) |=>
      (dac_data == $past(dac_data) || dac_data == $past(dac_data) + DACW'(1)));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && !sample_en) |=> slot == '0);

  assert_strobe_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe |-> $past(sample_en, 2));
endmodule

// File: tb/dither_seq_bench.sv
module dither_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0;
  logic        code_ld = 1'b0;
  logic [11:0] code_in = '0;
  logic [1:0]  res_sel = '0;
  logic [7:0]  dac_data;
  logic        dac_strobe;

  int checks = 0;
  int errors = 0;
  int m_slot = 0;
  int m_res = 0;
  logic [11:0] m_pend = '0;
  logic [11:0] m_act = '0;
  bit done = 0;

  always #2 clk = ~clk;

  dither_seq u_dither_seq (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .code_ld(code_ld),
    .code_in(code_in), .res_sel(res_sel), .dac_data(dac_data), .dac_strobe(dac_strobe)
  );

  function automatic int exp_out(input logic [11:0] code, input int r, input int s);
    int p, lim, c, b, k;
    p = 1 << (r + 1);
    lim = 255 * p;
    c = (int'(code) > lim) ? lim : int'(code);
    b = c / p;
    k = c % p;
    return (s >= p - k) ? b + 1 : b;
  endfunction

  task automatic check(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic load(input logic [11:0] v);
    @(negedge clk);
    code_ld = 1'b1;
    code_in = v;
    @(negedge clk);
    code_ld = 1'b0;
    m_pend = v;
  endtask

  task automatic set_res(input int r);
    @(negedge clk);
    res_sel = 2'(r);
    if (r != m_res) begin
      m_res = r;
      m_slot = 0;
    end
  endtask

  task automatic sample_once(input string req, output int got);
    int e;
    @(negedge clk);
    sample_en = 1'b1;
    if (m_slot == 0) m_act = m_pend;
    e = exp_out(m_act, m_res, m_slot);
    m_slot = (m_slot + 1) % (1 << (m_res + 1));
    @(negedge clk);
    sample_en = 1'b0;
    got = int'(dac_data);
    check(req, int'(dac_data), e);
    check("R8 strobe low on update cycle", int'(dac_strobe), 0);
    @(negedge clk);
    check("R8 strobe one cycle later", int'(dac_strobe), 1);
    check("R6 data holds without sample", int'(dac_data), e);
  endtask

  task automatic run_samples(input int n, input string req);
    int g;
    for (int i = 0; i < n; i++) sample_once(req, g);
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    check("R9 reset data", int'(dac_data), 0);
    check("R9 reset strobe", int'(dac_strobe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_samples(2, "R9 zero target after reset");

    set_res(1);
    load(12'd501);
    run_samples(4, "R3 k=1 only last slot high");
    load(12'd502);
    run_samples(8, "R3 k=2 last two slots high");
    load(12'd503);
    run_samples(4, "R3 k=3 at 10 bits");

    set_res(3);
    load(12'd100);
    sample_once("R5 first slot of new target", g);
    load(12'd3000);
    run_samples(15, "R5 target kept until boundary");
    run_samples(16, "R2 base and fraction at 12 bits");

    set_res(1);
    load(12'd1020);
    run_samples(4, "R4 largest valid code");
    load(12'd1023);
    run_samples(4, "R4 flat top clamped");
    set_res(0);
    load(12'd4095);
    run_samples(4, "R4 clamp at 9 bits");
    set_res(2);
    run_samples(8, "R4 clamp at 11 bits");

    load(12'd13);
    sample_once("R1 11-bit period", g);
    sample_once("R1 11-bit period", g);
    set_res(3);
    run_samples(16, "R7 restart on resolution change");
    set_res(0);
    run_samples(3, "R1 9-bit period");

    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom % 10);
      if (op == 0) set_res(int'($urandom % 4));
      else if (op < 3) load(12'($urandom % 4096));
      else sample_once("R3 random pattern vs model", g);
    end
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule